// File: doc/BRIEF.md
# One-Time-Programmable Direct Access Controller

This block gives a register interface word-level access to a small one-time-programmable store. Software stages a byte address and up to two 32-bit data words, then fires a single-shot command to read, program, or seal a partition. The store is a flop array with fuse-like behaviour: a bit that has been set cannot be cleared. The store is split into equal partitions. Each partition has a fixed access granule of 32 or 64 bits, and its last word holds a seal value.

Sealing a partition folds all of its data words together with XOR, mixes in a fixed salt, and writes the result into the partition's last word. A partition whose last word is nonzero is locked against further programming and sealing. Each command ends with a one-cycle completion pulse and a 3-bit result code. Errors also pulse an error flag. An escalation input drives the controller into a terminal state that nothing but reset can leave.

The controller is one sparse-coded state machine:

- IDLE accepts a command and moves to RD, PRG or SCAN.
- RD and PRG each return to IDLE after one cycle.
- SCAN walks the partition's data words one per cycle, then moves to STORE. If the partition is locked or out of range, SCAN returns to IDLE at once.
- STORE writes the seal and returns to IDLE.
- Escalation or an illegal state code moves any state to TERM. TERM only loops to itself.

Top module: `otp_dai_ctrl`

## Requirements
- R1: After reset, regwen_o and idle_o are 1, err_code_o is 0, done_o and err_o are 0, and rdata0_o and rdata1_o are 0.
- R2: A command starts only in IDLE and only when exactly one bit of cmd_i is set: bit 0 reads, bit 1 programs, bit 2 seals the partition holding the address. Any other cmd_i value is ignored, with no completion pulse.
- R3: The granule depends on the address. Partitions 0 and 1 (bytes 0x00-0x7F) use 32 bits, and address bits 1:0 are ignored. Partitions 2 and 3 (bytes 0x80-0xFF) use 64 bits, and address bits 2:0 are ignored. A 64-bit access uses both data words, with word 0 at the lower address. A 32-bit read returns 0 on rdata1_o.
- R4: regwen_o is 0 whenever a command is in flight. Writes to the staged address and data registers while it is 0 are ignored.
- R5: A program command that would turn any already-set bit to 0 completes with code 4 and leaves the store unchanged. Otherwise the target word(s) take the new value.
- R6: Three cases complete with code 5 and leave the store unchanged: an address at or above 0x100; a program command that touches a partition's last word (the seal word); a program or seal command on a locked partition.
- R7: Sealing stores the XOR of the partition's 15 data words and 0x5A5AC3C3 into its seal word. The partition is then locked, and it stays readable.
- R8: Every completed command gives a one-cycle done_o pulse. err_o pulses in the same cycle when the code is nonzero. err_code_o holds the code until the next accepted command clears it. Codes: 0 none, 4 blank violation, 5 access, 7 terminal; 1, 2, 3 and 6 are reserved.
- R9: escalate_i moves the controller to TERM on the next edge. There it shows code 7 and pulses err_o once. idle_o and regwen_o stay 0, and all commands are ignored until reset.
- R10: idle_o is 1 only in IDLE. A command that arrives while busy is dropped and produces no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| escalate_i | input | 1 | Forces the terminal error state |
| addr_we_i | input | 1 | Write strobe for the staged address |
| addr_i | input | 11 | Byte address |
| wdata0_we_i | input | 1 | Write strobe for data word 0 |
| wdata0_i | input | 32 | Program data, lower word |
| wdata1_we_i | input | 1 | Write strobe for data word 1 |
| wdata1_i | input | 32 | Program data, upper word |
| cmd_i | input | 3 | Single-shot command bits |
| regwen_o | output | 1 | Staging registers writable |
| idle_o | output | 1 | Controller in IDLE |
| rdata0_o | output | 32 | Read data, lower word |
| rdata1_o | output | 32 | Read data, upper word |
| err_code_o | output | 3 | Result code of the last command |
| done_o | output | 1 | Command completion pulse |
| err_o | output | 1 | Error pulse |

## Verification
The assertions check, on every cycle, a set of properties that hold for any stimulus:

- No array write ever clears a set bit.
- The staged address and data stay frozen while regwen_o is low.
- done_o never lasts longer than one cycle.
- An error pulse always carries a nonzero code.
- Escalation reaches the terminal code on the next edge, and that code never leaves.

The directed scenarios show the behaviours that depend on stored contents and ordering:

- Granule alignment and the 64-bit word placement.
- The exact seal value and the lock that follows it.
- Recoverable codes clearing on the next command.
- Commands dropped while busy, and multi-bit commands being ignored.

// File: rtl/otp_dai_pkg.sv
package otp_dai_pkg;

    localparam int RD_PORTS = 3;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_MACRO     = 3'd1,
        ERR_ECC_FIX   = 3'd2,
        ERR_ECC_FATAL = 3'd3,
        ERR_BLANK     = 3'd4,
        ERR_LOCKED    = 3'd5,
        ERR_CHECK     = 3'd6,
        ERR_STATE     = 3'd7
    } dai_err_e;

    // Pairwise Hamming distance of at least 3 between all codes.
    typedef enum logic [5:0] {
        S_IDLE  = 6'b000111,
        S_RD    = 6'b011001,
        S_PRG   = 6'b101010,
        S_SCAN  = 6'b110100,
        S_STORE = 6'b000000,
        S_TERM  = 6'b111111
    } dai_state_e;

endpackage

// File: rtl/otp_dai_partmap.sv
module otp_dai_partmap #(
    parameter int ADDR_W     = 11,
    parameter int NUM_PARTS  = 4,
    parameter int PART_WORDS = 16,
    parameter int IDX_W      = 6,
    parameter logic [NUM_PARTS-1:0] PART_IS64 = 4'b1100
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_range_o,
    output logic              is64_o,
    output logic [IDX_W-1:0]  idx0_o,
    output logic [IDX_W-1:0]  idx1_o,
    output logic [IDX_W-1:0]  base_idx_o,
    output logic [IDX_W-1:0]  seal_idx_o
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int TOTAL  = NUM_PARTS * PART_WORDS;
    localparam int PW_LOG = $clog2(PART_WORDS);
    localparam int PART_W = IDX_W - PW_LOG;

    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] aligned;
    logic [PART_W-1:0] part;
    logic              unused_lo;

    assign widx      = addr_i[ADDR_W-1:2];
    assign unused_lo = ^addr_i[1:0];
    assign part      = widx[PW_LOG +: PART_W];

    always_comb begin
        in_range_o = (32'(widx) < TOTAL);
        is64_o     = PART_IS64[part];
        aligned    = is64_o ? {widx[WIDX_W-1:1], 1'b0} : widx;
        idx0_o     = aligned[IDX_W-1:0];
        idx1_o     = {aligned[IDX_W-1:1], 1'b1};
        base_idx_o = {part, {PW_LOG{1'b0}}};
        seal_idx_o = {part, {PW_LOG{1'b1}}};
    end

endmodule

// File: rtl/otp_dai_array.sv
module otp_dai_array
    import otp_dai_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx_i,
    output logic [RD_PORTS-1:0][DATA_W-1:0]    rd_data_o,
    input  logic [1:0]                         we_i,
    input  logic [1:0][IDX_W-1:0]              wr_idx_i,
    input  logic [1:0][DATA_W-1:0]             wr_data_i
);
    logic [DATA_W-1:0] mem_q [WORDS];

    // Fuse model: a write can only set bits.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mem_q[w] <= '0;
            end else if (we_i[0] && wr_idx_i[0] == IDX_W'(w)) begin
                mem_q[w] <= mem_q[w] | wr_data_i[0];
            end else if (we_i[1] && wr_idx_i[1] == IDX_W'(w)) begin
                mem_q[w] <= mem_q[w] | wr_data_i[1];
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data_o[p] = mem_q[rd_idx_i[p]];
    end

    // R5: the controller never asks the store to drop a set bit
    a_r5_no_bit_cleared_p0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i[0] |-> ((wr_data_i[0] & mem_q[wr_idx_i[0]]) == mem_q[wr_idx_i[0]]));
    a_r5_no_bit_cleared_p1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i[1] |-> ((wr_data_i[1] & mem_q[wr_idx_i[1]]) == mem_q[wr_idx_i[1]]));

endmodule

// File: rtl/otp_dai_fsm.sv
module otp_dai_fsm
    import otp_dai_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int DATA_W     = 32,
    parameter int PART_WORDS = 16,
    parameter logic [DATA_W-1:0] DIGEST_SALT = 32'h5A5AC3C3
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            escalate_i,
    input  logic [2:0]                      cmd_i,
    input  logic                            in_range_i,
    input  logic                            is64_i,
    input  logic [IDX_W-1:0]                idx0_i,
    input  logic [IDX_W-1:0]                idx1_i,
    input  logic [IDX_W-1:0]                base_idx_i,
    input  logic [IDX_W-1:0]                seal_idx_i,
    input  logic [DATA_W-1:0]               wdata0_i,
    input  logic [DATA_W-1:0]               wdata1_i,
    input  logic [RD_PORTS-1:0][DATA_W-1:0] rd_data_i,
    output logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx_o,
    output logic [1:0]                      we_o,
    output logic [1:0][IDX_W-1:0]           wr_idx_o,
    output logic [1:0][DATA_W-1:0]          wr_data_o,
    output logic [DATA_W-1:0]               rdata0_o,
    output logic [DATA_W-1:0]               rdata1_o,
    output logic [2:0]                      err_code_o,
    output logic                            done_o,
    output logic                            err_o,
    output logic                            idle_o
);
    localparam int PW_LOG = $clog2(PART_WORDS);
    localparam logic [PW_LOG-1:0] LAST_DATA = PW_LOG'(PART_WORDS - 2);

    dai_state_e        state_q, state_d;
    dai_err_e          code_q, fin_code;
    logic              fin, accept, enter_term;
    logic              locked, blank_viol, hits_seal;
    logic [PW_LOG-1:0] cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic              done_q, err_q;
    logic [DATA_W-1:0] rdata0_q, rdata1_q;

    assign locked     = (rd_data_i[2] != '0);
    assign blank_viol = ((rd_data_i[0] & ~wdata0_i) != '0) ||
                        (is64_i && ((rd_data_i[1] & ~wdata1_i) != '0));
    assign hits_seal  = (idx0_i == seal_idx_i) || (is64_i && idx1_i == seal_idx_i);
    assign accept     = (state_q == S_IDLE) && $onehot(cmd_i);

    assign rd_idx_o[0] = (state_q == S_SCAN) ? {base_idx_i[IDX_W-1:PW_LOG], cnt_q} : idx0_i;
    assign rd_idx_o[1] = idx1_i;
    assign rd_idx_o[2] = seal_idx_i;

    assign wr_idx_o[0]  = (state_q == S_STORE) ? seal_idx_i : idx0_i;
    assign wr_idx_o[1]  = idx1_i;
    assign wr_data_o[0] = (state_q == S_STORE) ? (acc_q ^ DIGEST_SALT) : wdata0_i;
    assign wr_data_o[1] = wdata1_i;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // Next state and store controls
    always_comb begin
        state_d  = state_q;
        we_o     = 2'b00;
        fin      = 1'b0;
        fin_code = ERR_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (cmd_i[0])      state_d = S_RD;
                    else if (cmd_i[1]) state_d = S_PRG;
                    else               state_d = S_SCAN;
                end
            end
            S_RD: begin
                fin     = 1'b1;
                state_d = S_IDLE;
                if (!in_range_i) fin_code = ERR_LOCKED;
            end
            S_PRG: begin
                fin     = 1'b1;
                state_d = S_IDLE;
                if (!in_range_i || hits_seal || locked) begin
                    fin_code = ERR_LOCKED;
                end else if (blank_viol) begin
                    fin_code = ERR_BLANK;
                end else begin
                    we_o = {is64_i, 1'b1};
                end
            end
            S_SCAN: begin
                if (cnt_q == '0 && (!in_range_i || locked)) begin
                    fin      = 1'b1;
                    fin_code = ERR_LOCKED;
                    state_d  = S_IDLE;
                end else if (cnt_q == LAST_DATA) begin
                    state_d = S_STORE;
                end
            end
            S_STORE: begin
                we_o    = 2'b01;
                fin     = 1'b1;
                state_d = S_IDLE;
            end
            S_TERM: state_d = S_TERM;
            default: state_d = S_TERM;
        endcase
        if (escalate_i) begin
            state_d = S_TERM;
            we_o    = 2'b00;
            fin     = 1'b0;
        end
    end

    assign enter_term = (state_d == S_TERM) && (state_q != S_TERM);

    // Registered outputs and datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q   <= ERR_NONE;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cnt_q    <= '0;
            acc_q    <= '0;
            rdata0_q <= '0;
            rdata1_q <= '0;
        end else begin
            done_q <= fin;
            err_q  <= enter_term || (fin && fin_code != ERR_NONE);
            if (enter_term)  code_q <= ERR_STATE;
            else if (accept) code_q <= ERR_NONE;
            else if (fin)    code_q <= fin_code;
            if (accept) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else if (state_q == S_SCAN) begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= acc_q ^ rd_data_i[0];
            end
            if (state_q == S_RD && in_range_i && !escalate_i) begin
                rdata0_q <= rd_data_i[0];
                rdata1_q <= is64_i ? rd_data_i[1] : '0;
            end
        end
    end

    assign err_code_o = code_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign rdata0_o   = rdata0_q;
    assign rdata1_o   = rdata1_q;
    assign idle_o     = (state_q == S_IDLE);

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R8: an error pulse always carries a code
    a_r8_err_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (err_code_o != 3'd0));
    // R9: escalation lands in the terminal code on the next edge
    a_r9_escalate_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
        escalate_i |=> (err_code_o == 3'd7 && !idle_o));
    // R9: the terminal code never leaves
    a_r9_term_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_code_o == 3'd7) |=> (err_code_o == 3'd7));

endmodule

// File: rtl/otp_dai_ctrl.sv
module otp_dai_ctrl
    import otp_dai_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 32,
    parameter int NUM_PARTS  = 4,
    parameter int PART_WORDS = 16,
    parameter logic [NUM_PARTS-1:0] PART_IS64   = 4'b1100,
    parameter logic [DATA_W-1:0]    DIGEST_SALT = 32'h5A5AC3C3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              escalate_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wdata0_we_i,
    input  logic [DATA_W-1:0] wdata0_i,
    input  logic              wdata1_we_i,
    input  logic [DATA_W-1:0] wdata1_i,
    input  logic [2:0]        cmd_i,
    output logic              regwen_o,
    output logic              idle_o,
    output logic [DATA_W-1:0] rdata0_o,
    output logic [DATA_W-1:0] rdata1_o,
    output logic [2:0]        err_code_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int WORDS = NUM_PARTS * PART_WORDS;
    localparam int IDX_W = $clog2(WORDS);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd0_q, wd1_q;
    logic              in_range, is64;
    logic [IDX_W-1:0]  idx0, idx1, base_idx, seal_idx;
    logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
    logic [RD_PORTS-1:0][DATA_W-1:0] rd_data;
    logic [1:0]                      we;
    logic [1:0][IDX_W-1:0]           wr_idx;
    logic [1:0][DATA_W-1:0]          wr_data;
    logic                            idle;

    assign regwen_o = idle;
    assign idle_o   = idle;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
            wd0_q  <= '0;
            wd1_q  <= '0;
        end else if (regwen_o) begin
            if (addr_we_i)   addr_q <= addr_i;
            if (wdata0_we_i) wd0_q  <= wdata0_i;
            if (wdata1_we_i) wd1_q  <= wdata1_i;
        end
    end

    otp_dai_partmap #(
        .ADDR_W(ADDR_W), .NUM_PARTS(NUM_PARTS), .PART_WORDS(PART_WORDS),
        .IDX_W(IDX_W), .PART_IS64(PART_IS64)
    ) u_partmap (
        .addr_i(addr_q), .in_range_o(in_range), .is64_o(is64),
        .idx0_o(idx0), .idx1_o(idx1), .base_idx_o(base_idx), .seal_idx_o(seal_idx)
    );

    otp_dai_array #(.WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
        .clk_i(clk_i), .rst_ni(rst_ni), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .we_i(we), .wr_idx_i(wr_idx), .wr_data_i(wr_data)
    );

    otp_dai_fsm #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .PART_WORDS(PART_WORDS), .DIGEST_SALT(DIGEST_SALT)
    ) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .escalate_i(escalate_i), .cmd_i(cmd_i),
        .in_range_i(in_range), .is64_i(is64), .idx0_i(idx0), .idx1_i(idx1),
        .base_idx_i(base_idx), .seal_idx_i(seal_idx), .wdata0_i(wd0_q), .wdata1_i(wd1_q),
        .rd_data_i(rd_data), .rd_idx_o(rd_idx), .we_o(we), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data), .rdata0_o(rdata0_o), .rdata1_o(rdata1_o),
        .err_code_o(err_code_o), .done_o(done_o), .err_o(err_o), .idle_o(idle)
    );

    // R4: staged operands are frozen while writes are disabled
    a_r4_staging_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !regwen_o |=> ($stable(addr_q) && $stable(wd0_q) && $stable(wd1_q)));

endmodule

// File: tb/otp_dai_ctrl_bench.sv
module otp_dai_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        esc = 1'b0;
    logic        addr_we = 1'b0, wd0_we = 1'b0, wd1_we = 1'b0;
    logic [10:0] addr = '0;
    logic [31:0] wd0 = '0, wd1 = '0;
    logic [2:0]  cmd = '0;
    logic        regwen, idle, done, err;
    logic [31:0] rd0, rd1;
    logic [2:0]  code;

    int errors = 0;
    int checks = 0;
    localparam logic [31:0] SALT = 32'h5A5AC3C3;

    always #5 clk = ~clk;

    otp_dai_ctrl u_otp_dai_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .escalate_i(esc),
        .addr_we_i(addr_we), .addr_i(addr), .wdata0_we_i(wd0_we), .wdata0_i(wd0),
        .wdata1_we_i(wd1_we), .wdata1_i(wd1), .cmd_i(cmd), .regwen_o(regwen),
        .idle_o(idle), .rdata0_o(rd0), .rdata1_o(rd1), .err_code_o(code),
        .done_o(done), .err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic stage(input logic [10:0] a, input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        addr_we = 1; addr = a; wd0_we = 1; wd0 = d0; wd1_we = 1; wd1 = d1;
        @(negedge clk);
        addr_we = 0; wd0_we = 0; wd1_we = 0;
    endtask

    // Pulse a command, then wait (sampling at negedges) for completion.
    task automatic fire(input logic [2:0] c, output logic got, output logic eflag);
        got = 0; eflag = 0;
        @(negedge clk); cmd = c;
        @(negedge clk); cmd = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (done) begin got = 1; eflag = err; end
            else @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, output logic seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic run(input string req, input logic [2:0] c, input logic [10:0] a,
                       input logic [31:0] d0, input logic [31:0] d1, input logic [2:0] exp_code);
        logic got, ef;
        stage(a, d0, d1);
        fire(c, got, ef);
        chk({req, " done"}, {31'b0, got}, 32'd1);
        chk({req, " code"}, {29'b0, code}, {29'b0, exp_code});
        chk({req, " err"}, {31'b0, ef}, {31'b0, exp_code != 3'd0});
    endtask

    task automatic t_reset;   // R1
        chk("R1 regwen", {31'b0, regwen}, 1);
        chk("R1 idle", {31'b0, idle}, 1);
        chk("R1 code", {29'b0, code}, 0);
        chk("R1 done/err", {30'b0, done, err}, 0);
        chk("R1 rdata", rd0 | rd1, 0);
    endtask

    task automatic t_prog32;  // R2 R3 R5
        run("R5 prog32", 3'b010, 11'h017, 32'h0000F0F0, 32'hFFFFFFFF, 3'd0);
        run("R3 read32", 3'b001, 11'h016, 0, 0, 3'd0);
        chk("R3 rdata0 aligned 32", rd0, 32'h0000F0F0);
        chk("R3 rdata1 zero on 32", rd1, 0);
    endtask

    task automatic t_blank;   // R5 R8
        run("R5 blank viol", 3'b010, 11'h014, 32'h000000F0, 0, 3'd4);
        run("R8 code clears", 3'b001, 11'h014, 0, 0, 3'd0);
        chk("R5 unchanged", rd0, 32'h0000F0F0);
        run("R5 superset", 3'b010, 11'h014, 32'h0F0FF0F0, 0, 3'd0);
        run("R5 read superset", 3'b001, 11'h014, 0, 0, 3'd0);
        chk("R5 superset data", rd0, 32'h0F0FF0F0);
    endtask

    task automatic t_prog64;  // R3
        run("R3 prog64", 3'b010, 11'h08C, 32'h12345678, 32'h9ABCDEF0, 3'd0);
        run("R3 read64", 3'b001, 11'h08F, 0, 0, 3'd0);
        chk("R3 rdata0 64", rd0, 32'h12345678);
        chk("R3 rdata1 64", rd1, 32'h9ABCDEF0);
    endtask

    task automatic t_access;  // R6
        run("R6 out of range", 3'b001, 11'h104, 0, 0, 3'd5);
        run("R6 seal word prog32", 3'b010, 11'h03C, 32'h1, 0, 3'd5);
        run("R6 seal word prog64", 3'b010, 11'h0B8, 32'h1, 32'h1, 3'd5);
        run("R6 seal word kept", 3'b001, 11'h0B8, 0, 0, 3'd0);
        chk("R6 seal word blank", rd0 | rd1, 0);
    endtask

    task automatic t_seal;    // R7 R6
        run("R7 seal p0", 3'b100, 11'h000, 0, 0, 3'd0);
        run("R7 read seal", 3'b001, 11'h03C, 0, 0, 3'd0);
        chk("R7 seal value", rd0, 32'h0F0FF0F0 ^ SALT);
        run("R6 prog locked", 3'b010, 11'h020, 32'h1, 0, 3'd5);
        run("R6 locked unchanged", 3'b001, 11'h020, 0, 0, 3'd0);
        chk("R6 locked word", rd0, 0);
        run("R6 reseal locked", 3'b100, 11'h010, 0, 0, 3'd5);
        run("R7 seal kept", 3'b001, 11'h03C, 0, 0, 3'd0);
        chk("R7 seal unchanged", rd0, 32'h0F0FF0F0 ^ SALT);
    endtask

    task automatic t_busy;    // R4 R10
        logic got, ef, seen;
        stage(11'h07C, 0, 0);
        @(negedge clk); cmd = 3'b100;
        @(negedge clk); cmd = 0; addr_we = 1; addr = 11'h014;
        chk("R4 regwen low busy", {31'b0, regwen}, 0);
        chk("R10 idle low busy", {31'b0, idle}, 0);
        @(negedge clk); addr_we = 0; cmd = 3'b001;
        @(negedge clk); cmd = 0;
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (done) got = 1; else @(negedge clk);
        end
        chk("R10 seal done", {31'b0, got}, 1);
        quiet(5, seen);
        chk("R10 dropped cmd no done", {31'b0, seen}, 0);
        chk("R4 regwen back", {31'b0, regwen}, 1);
        fire(3'b001, got, ef);
        chk("R4 addr kept", rd0, SALT);
    endtask

    task automatic t_multi;   // R2
        logic seen;
        stage(11'h014, 0, 0);
        @(negedge clk); cmd = 3'b011;
        @(negedge clk); cmd = 0;
        chk("R2 multi-bit stays idle", {31'b0, idle}, 1);
        quiet(6, seen);
        chk("R2 multi-bit no done", {31'b0, seen}, 0);
    endtask

    task automatic t_escalate; // R9
        logic seen;
        @(negedge clk); esc = 1;
        @(negedge clk); esc = 0;
        chk("R9 code 7", {29'b0, code}, 7);
        chk("R9 err pulse", {31'b0, err}, 1);
        chk("R9 idle low", {31'b0, idle}, 0);
        chk("R9 regwen low", {31'b0, regwen}, 0);
        @(negedge clk); cmd = 3'b001;
        @(negedge clk); cmd = 0;
        quiet(6, seen);
        chk("R9 cmd ignored", {31'b0, seen}, 0);
        chk("R9 code sticky", {29'b0, code}, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_prog32();
        t_blank();
        t_prog64();
        t_access();
        t_seal();
        t_busy();
        t_multi();
        t_escalate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule